// File: doc/BRIEF.md
# Pager Decoder Status Event Register

This block gathers the event strobes that a paging-protocol decoder core produces (sync acquisition and loss, search-window expiry, battery-pin samples, the minute tick, frame ends, the end of address processing and transmit-queue overflow). It turns each of them into a sticky flag under its own qualifying rule, and offers the collected flags to the host packet path as one status word. A flag is cleared when the host takes the word. The block also keeps the current system cycle number, which is refreshed at the end of block 0 of every frame. On a transmit-queue overflow it asks the queue to flush and forces the decoder enable off.

The status word leaves the block over a valid/ready pair. `stat_valid` is high while at least one flag is set and the transmit queue holds no data packets. A data packet therefore always goes out ahead of the status word, and a word that carries the end-of-addresses flag follows every address packet of its frame.

Back-pressure works as follows. While `stat_ready` is low, the flags are held and can only gain bits, never lose them. A transfer happens on a clock edge where `stat_valid` and `stat_ready` are both high, and it clears every flag except the ones whose event arrives on that same edge. The host receives the value the word had before that edge.

Top module: `pager_status_events`

## Requirements
- R1: After reset, all six flags are 0, the cycle number is 0, and `stat_valid`, `fifo_flush` and `dec_force_off` are low. Flag bit positions in `stat_flags`: 0 sync-mode update, 1 battery update, 2 minute, 3 frame end, 4 address end, 5 overflow.
- R2: After the decoder is enabled, the first sync-mode update sets bit 0. It happens either when `sync_state` rises or when `win_expire` pulses while `sync_state` is 0. Once that first update has happened, a later `win_expire` does not set bit 0.
- R3: After the first update, every change of `sync_state` while enabled sets bit 0. A change seen while `dec_en` is low (including one in the cycle the decoder is turned off) does not set it, and turning the decoder off re-arms the first-update rule.
- R4: Bit 1 sets when two consecutive `batt_sample` samples of `batt_pin`, taken while enabled, differ. The first sample after enabling is only a baseline, and samples taken while disabled are ignored.
- R5: Each `minute_tick` pulse sets bit 2.
- R6: `frame_end` sets bit 3 only while all-frames mode is active, meaning `afm_cnt_nz` is high, any bit of `tmp_cnt_nz` is high, or `force_all` is high.
- R7: `last_addr_done` sets bit 4 only if `ea_enable` is high and `addr_hit` pulsed since the previous `frame_end` or `last_addr_done`.
- R8: An `fifo_overflow` pulse sets bit 5, and in the next cycle `fifo_flush` and `dec_force_off` are high for exactly one cycle.
- R9: A transfer clears all flags. An event on the transfer edge leaves its flag set, while the transferred word shows the flags from before that edge.
- R10: `stat_valid` is high exactly when some flag is set and `txq_nonempty` is low. With `stat_ready` held high but `stat_valid` low, no flag is cleared.
- R11: `cycle_num` takes `cycle_in` on every `blk0_end` pulse whatever `dec_en` is, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Decoder enable state |
| sync_state | input | 1 | Current synchronous-mode level |
| win_expire | input | 1 | Initial sync search window expired (pulse) |
| batt_sample | input | 1 | Host-commanded battery sample strobe |
| batt_pin | input | 1 | Battery-low pin level |
| minute_tick | input | 1 | One minute elapsed (pulse) |
| frame_end | input | 1 | End of frame (pulse) |
| afm_cnt_nz | input | 1 | All-frames enable counter is nonzero |
| tmp_cnt_nz | input | N_TMP | Per temporary-address counter nonzero |
| force_all | input | 1 | Forced all-frames bit |
| addr_hit | input | 1 | Address detected in the current frame (pulse) |
| last_addr_done | input | 1 | Last address of the frame processed (pulse) |
| ea_enable | input | 1 | End-of-addresses reporting enable |
| blk0_end | input | 1 | End of block 0 of a frame (pulse) |
| cycle_in | input | CYC_W | Cycle number from the frame decoder |
| fifo_overflow | input | 1 | Transmit queue overflowed (pulse) |
| txq_nonempty | input | 1 | Data packets are waiting in the transmit queue |
| stat_ready | input | 1 | Host accepts the status word |
| stat_valid | output | 1 | Status word available |
| stat_flags | output | 6 | Status word flags |
| cycle_num | output | CYC_W | Latched cycle number |
| fifo_flush | output | 1 | Flush request to the transmit queue |
| dec_force_off | output | 1 | Clears the decoder enable |

## Verification
The hardest situation to reach is the sync-update rule after a power cycle of the decoder. The first-update condition has to be consumed, then disarmed by a disable that happens in the same cycle as a sync loss, and then re-armed. The directed task first consumes the first update through a window expiry and shows that a second expiry is ignored. It then toggles sync to show transition tracking, and drops `dec_en` together with `sync_state`, expecting no flag. Finally it re-enables the decoder and shows that the first-update rule applies again. A second awkward case is an event that lands on the very edge of a transfer. The bench raises `stat_ready` and `minute_tick` in the same cycle and checks both the value it captured and the flag that remains.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int NFLAG  = 6;
  localparam int F_SYNC = 0;
  localparam int F_BATT = 1;
  localparam int F_MIN  = 2;
  localparam int F_FEND = 3;
  localparam int F_AEND = 4;
  localparam int F_OVF  = 5;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/psr_sync_tracker.sv
module psr_sync_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_en,
  input  logic sync_state,
  input  logic win_expire,
  output logic upd
);
  logic first_done_q;
  logic prev_q;
  logic rose;
  logic changed;

  always_comb begin
    changed = sync_state ^ prev_q;
    rose    = sync_state & ~prev_q;
    if (!dec_en)
      upd = 1'b0;
    else if (first_done_q)
      upd = changed;
    else
      upd = rose | (win_expire & ~sync_state);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_done_q <= 1'b0;
      prev_q       <= 1'b0;
    end else begin
      prev_q <= sync_state;
      if (!dec_en)
        first_done_q <= 1'b0;
      else if (upd)
        first_done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/psr_batt_tracker.sv
module psr_batt_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_en,
  input  logic sample_stb,
  input  logic batt_pin,
  output logic upd
);
  logic have_q;
  logic last_q;

  always_comb begin
    upd = dec_en & sample_stb & have_q & (batt_pin ^ last_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= 1'b0;
    end else if (!dec_en) begin
      have_q <= 1'b0;
    end else if (sample_stb) begin
      have_q <= 1'b1;
      last_q <= batt_pin;
    end
  end
endmodule

// File: rtl/psr_frame_events.sv
module psr_frame_events #(
  parameter int N_TMP = 4,
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             afm_cnt_nz,
  input  logic [N_TMP-1:0] tmp_cnt_nz,
  input  logic             force_all,
  input  logic             addr_hit,
  input  logic             last_addr_done,
  input  logic             ea_enable,
  input  logic             blk0_end,
  input  logic [CYC_W-1:0] cycle_in,
  output logic             fend_evt,
  output logic             aend_evt,
  output logic [CYC_W-1:0] cycle_num
);
  logic all_frames;
  logic seen_q;

  always_comb begin
    all_frames = afm_cnt_nz | (|tmp_cnt_nz) | force_all;
    fend_evt   = frame_end & all_frames;
    aend_evt   = last_addr_done & ea_enable & (seen_q | addr_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      cycle_num <= '0;
    end else begin
      if (frame_end || last_addr_done)
        seen_q <= 1'b0;
      else if (addr_hit)
        seen_q <= 1'b1;
      if (blk0_end)
        cycle_num <= cycle_in;
    end
  end
endmodule

// File: rtl/psr_flag_bank.sv
module psr_flag_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else
        flags[i] <= set_vec[i] | (flags[i] & ~clr);
    end
  end
endmodule

// File: rtl/pager_status_events.sv
module pager_status_events
  import psr_pkg::*;
#(
  parameter int N_TMP = 4,
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic             sync_state,
  input  logic             win_expire,
  input  logic             batt_sample,
  input  logic             batt_pin,
  input  logic             minute_tick,
  input  logic             frame_end,
  input  logic             afm_cnt_nz,
  input  logic [N_TMP-1:0] tmp_cnt_nz,
  input  logic             force_all,
  input  logic             addr_hit,
  input  logic             last_addr_done,
  input  logic             ea_enable,
  input  logic             blk0_end,
  input  logic [CYC_W-1:0] cycle_in,
  input  logic             fifo_overflow,
  input  logic             txq_nonempty,
  input  logic             stat_ready,
  output logic             stat_valid,
  output logic [NFLAG-1:0] stat_flags,
  output logic [CYC_W-1:0] cycle_num,
  output logic             fifo_flush,
  output logic             dec_force_off
);
  logic      sync_upd;
  logic      batt_upd;
  logic      fend_evt;
  logic      aend_evt;
  logic      ovf_q;
  logic      xfer;
  flag_vec_t set_vec;

  psr_sync_tracker u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_en     (dec_en),
    .sync_state (sync_state),
    .win_expire (win_expire),
    .upd        (sync_upd)
  );

  psr_batt_tracker u_batt (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_en     (dec_en),
    .sample_stb (batt_sample),
    .batt_pin   (batt_pin),
    .upd        (batt_upd)
  );

  psr_frame_events #(.N_TMP(N_TMP), .CYC_W(CYC_W)) u_frame (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_end      (frame_end),
    .afm_cnt_nz     (afm_cnt_nz),
    .tmp_cnt_nz     (tmp_cnt_nz),
    .force_all      (force_all),
    .addr_hit       (addr_hit),
    .last_addr_done (last_addr_done),
    .ea_enable      (ea_enable),
    .blk0_end       (blk0_end),
    .cycle_in       (cycle_in),
    .fend_evt       (fend_evt),
    .aend_evt       (aend_evt),
    .cycle_num      (cycle_num)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[F_SYNC] = sync_upd;
    set_vec[F_BATT] = batt_upd;
    set_vec[F_MIN]  = minute_tick;
    set_vec[F_FEND] = fend_evt;
    set_vec[F_AEND] = aend_evt;
    set_vec[F_OVF]  = fifo_overflow;
    stat_valid      = (|stat_flags) & ~txq_nonempty;
    xfer            = stat_valid & stat_ready;
  end

  psr_flag_bank #(.W(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (xfer),
    .flags   (stat_flags)
  );

  // Overflow recovery: one-cycle flush and enable knock-out after the event.
  always_ff @(posedge clk) begin
    if (!rst_n)
      ovf_q <= 1'b0;
    else
      ovf_q <= fifo_overflow;
  end

  assign fifo_flush    = ovf_q;
  assign dec_force_off = ovf_q;
endmodule

// File: rtl/pager_status_events_chk.sv
module pager_status_events_chk
  import psr_pkg::*;
#(
  parameter int N_TMP = 4,
  parameter int CYC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_en,
  input logic             frame_end,
  input logic             afm_cnt_nz,
  input logic [N_TMP-1:0] tmp_cnt_nz,
  input logic             force_all,
  input logic             blk0_end,
  input logic [CYC_W-1:0] cycle_in,
  input logic             fifo_overflow,
  input logic             txq_nonempty,
  input logic             stat_ready,
  input logic             stat_valid,
  input logic [NFLAG-1:0] stat_flags,
  input logic [CYC_W-1:0] cycle_num,
  input logic             fifo_flush,
  input logic             dec_force_off,
  input logic [NFLAG-1:0] set_vec
);
  assert_sync_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !stat_flags[F_SYNC]) |=> !stat_flags[F_SYNC]);

  assert_fend_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !afm_cnt_nz && (tmp_cnt_nz == '0) && !force_all && !stat_flags[F_FEND])
      |=> !stat_flags[F_FEND]);

  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |=> (fifo_flush && dec_force_off && stat_flags[F_OVF]));

  assert_flush_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_overflow |=> (!fifo_flush && !dec_force_off));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_ready) |=> (stat_flags == $past(set_vec)));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_valid && stat_ready) |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags)));

  assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    txq_nonempty |-> !stat_valid);

  assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_flags != '0));

  assert_cycle_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blk0_end |=> (cycle_num == $past(cycle_in)));

  assert_cycle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !blk0_end |=> $stable(cycle_num));
endmodule

bind pager_status_events pager_status_events_chk #(.N_TMP(N_TMP), .CYC_W(CYC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_en        (dec_en),
  .frame_end     (frame_end),
  .afm_cnt_nz    (afm_cnt_nz),
  .tmp_cnt_nz    (tmp_cnt_nz),
  .force_all     (force_all),
  .blk0_end      (blk0_end),
  .cycle_in      (cycle_in),
  .fifo_overflow (fifo_overflow),
  .txq_nonempty  (txq_nonempty),
  .stat_ready    (stat_ready),
  .stat_valid    (stat_valid),
  .stat_flags    (stat_flags),
  .cycle_num     (cycle_num),
  .fifo_flush    (fifo_flush),
  .dec_force_off (dec_force_off),
  .set_vec       (set_vec)
);

// File: tb/pager_status_events_bench.sv
module pager_status_events_bench;
  localparam int N_TMP = 4;
  localparam int CYC_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_en = 0, sync_state = 0, win_expire = 0, batt_sample = 0, batt_pin = 0;
  logic minute_tick = 0, frame_end = 0, afm_cnt_nz = 0, force_all = 0;
  logic [N_TMP-1:0] tmp_cnt_nz = '0;
  logic addr_hit = 0, last_addr_done = 0, ea_enable = 0, blk0_end = 0;
  logic [CYC_W-1:0] cycle_in = '0;
  logic fifo_overflow = 0, txq_nonempty = 0, stat_ready = 0;
  logic stat_valid, fifo_flush, dec_force_off;
  logic [5:0] stat_flags;
  logic [CYC_W-1:0] cycle_num;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pager_status_events #(.N_TMP(N_TMP), .CYC_W(CYC_W)) u_pager_status_events (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .sync_state(sync_state),
    .win_expire(win_expire), .batt_sample(batt_sample), .batt_pin(batt_pin),
    .minute_tick(minute_tick), .frame_end(frame_end), .afm_cnt_nz(afm_cnt_nz),
    .tmp_cnt_nz(tmp_cnt_nz), .force_all(force_all), .addr_hit(addr_hit),
    .last_addr_done(last_addr_done), .ea_enable(ea_enable), .blk0_end(blk0_end),
    .cycle_in(cycle_in), .fifo_overflow(fifo_overflow), .txq_nonempty(txq_nonempty),
    .stat_ready(stat_ready), .stat_valid(stat_valid), .stat_flags(stat_flags),
    .cycle_num(cycle_num), .fifo_flush(fifo_flush), .dec_force_off(dec_force_off)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Takes the status word; returns what was presented before the edge.
  task automatic take(output logic [5:0] got);
    got = stat_flags;
    stat_ready = 1'b1;
    tick();
    stat_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flags", stat_flags, 0);
    chk("R1 cycle", cycle_num, 0);
    chk("R1 valid", stat_valid, 0);
    chk("R1 flush", fifo_flush, 0);
    chk("R1 forceoff", dec_force_off, 0);
  endtask

  task automatic t_sync();
    logic [5:0] g;
    dec_en = 1; tick();
    chk("R2 idle after enable", stat_flags, 0);
    win_expire = 1; tick(); win_expire = 0;
    chk("R2 window expiry first update", stat_flags, 6'h01);
    take(g);
    chk("R9 cleared", stat_flags, 0);
    win_expire = 1; tick(); win_expire = 0;
    chk("R2 second expiry ignored", stat_flags, 0);
    sync_state = 1; tick();
    chk("R3 sync gained", stat_flags, 6'h01);
    take(g);
    sync_state = 0; tick();
    chk("R3 sync lost", stat_flags, 6'h01);
    take(g);
    sync_state = 1; tick(); take(g);
    dec_en = 0; sync_state = 0; tick();
    chk("R3 loss from disable ignored", stat_flags, 0);
    tick();
    dec_en = 1; tick();
    chk("R3 quiet re-enable", stat_flags, 0);
    sync_state = 1; tick();
    chk("R2 first update re-armed", stat_flags, 6'h01);
    take(g);
    sync_state = 0; dec_en = 0; tick();
  endtask

  task automatic t_batt();
    logic [5:0] g;
    dec_en = 1; batt_pin = 1;
    batt_sample = 1; tick(); batt_sample = 0;
    chk("R4 baseline sample", stat_flags, 0);
    batt_sample = 1; tick(); batt_sample = 0;
    chk("R4 same sample", stat_flags, 0);
    batt_pin = 0; batt_sample = 1; tick(); batt_sample = 0;
    chk("R4 changed sample", stat_flags, 6'h02);
    take(g);
    dec_en = 0; batt_pin = 1; batt_sample = 1; tick(); batt_sample = 0;
    chk("R4 disabled sample ignored", stat_flags, 0);
    dec_en = 1; batt_sample = 1; tick(); batt_sample = 0;
    chk("R4 turn-on change ignored", stat_flags, 0);
    dec_en = 0; tick();
  endtask

  task automatic t_minute();
    logic [5:0] g;
    minute_tick = 1; tick(); minute_tick = 0;
    chk("R5 minute", stat_flags, 6'h04);
    chk("R10 valid with flag", stat_valid, 1);
    take(g);
    chk("R5 read value", g, 6'h04);
  endtask

  task automatic t_fend();
    logic [5:0] g;
    frame_end = 1; tick(); frame_end = 0;
    chk("R6 no all-frames mode", stat_flags, 0);
    tmp_cnt_nz = 4'b0100; frame_end = 1; tick(); frame_end = 0; tmp_cnt_nz = '0;
    chk("R6 temp counter", stat_flags, 6'h08);
    take(g);
    afm_cnt_nz = 1; frame_end = 1; tick(); frame_end = 0; afm_cnt_nz = 0;
    chk("R6 enable counter", stat_flags, 6'h08);
    take(g);
    force_all = 1; frame_end = 1; tick(); frame_end = 0; force_all = 0;
    chk("R6 forced", stat_flags, 6'h08);
    take(g);
  endtask

  task automatic t_aend();
    logic [5:0] g;
    ea_enable = 1;
    last_addr_done = 1; tick(); last_addr_done = 0;
    chk("R7 no address", stat_flags, 0);
    addr_hit = 1; tick(); addr_hit = 0; tick();
    last_addr_done = 1; tick(); last_addr_done = 0;
    chk("R7 address then last", stat_flags, 6'h10);
    take(g);
    addr_hit = 1; tick(); addr_hit = 0;
    frame_end = 1; tick(); frame_end = 0;
    last_addr_done = 1; tick(); last_addr_done = 0;
    chk("R7 frame end forgets address", stat_flags, 0);
    ea_enable = 0;
    addr_hit = 1; tick(); addr_hit = 0;
    last_addr_done = 1; tick(); last_addr_done = 0;
    chk("R7 disabled", stat_flags, 0);
  endtask

  task automatic t_overflow();
    logic [5:0] g;
    fifo_overflow = 1; tick(); fifo_overflow = 0;
    chk("R8 flag", stat_flags, 6'h20);
    chk("R8 flush", fifo_flush, 1);
    chk("R8 force off", dec_force_off, 1);
    tick();
    chk("R8 flush ends", fifo_flush, 0);
    chk("R8 force off ends", dec_force_off, 0);
    take(g);
  endtask

  task automatic t_race();
    logic [5:0] g;
    minute_tick = 1; tick(); minute_tick = 0;
    g = stat_flags;
    stat_ready = 1; minute_tick = 1; tick(); stat_ready = 0; minute_tick = 0;
    chk("R9 word before edge", g, 6'h04);
    chk("R9 event on read kept", stat_flags, 6'h04);
    take(g);
    chk("R9 final clear", stat_flags, 0);
  endtask

  task automatic t_priority();
    logic [5:0] g;
    minute_tick = 1; txq_nonempty = 1; tick(); minute_tick = 0;
    chk("R10 data first", stat_valid, 0);
    stat_ready = 1; tick(); stat_ready = 0;
    chk("R10 held under priority", stat_flags, 6'h04);
    txq_nonempty = 0; tick();
    chk("R10 valid released", stat_valid, 1);
    take(g);
    chk("R10 valid drops", stat_valid, 0);
  endtask

  task automatic t_cycle();
    dec_en = 0; cycle_in = 4'd5; blk0_end = 1; tick(); blk0_end = 0;
    chk("R11 load while off", cycle_num, 5);
    cycle_in = 4'd9; tick(); tick();
    chk("R11 hold", cycle_num, 5);
    dec_en = 1; blk0_end = 1; tick(); blk0_end = 0;
    chk("R11 load while on", cycle_num, 9);
    dec_en = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_sync();
    t_batt();
    t_minute();
    t_fend();
    t_aend();
    t_overflow();
    t_race();
    t_priority();
    t_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule